// File: doc/BRIEF.md
# Debounced Edge-Interrupt Input Controller

This block watches a bank of asynchronous digital input lines (16 by default) for a register-mapped I/O card. Each line passes through a two-flop synchronizer. When the shared debounce mode is on, the line then passes through its own small debounce state machine. Rising and falling transitions of the resulting level are caught per line. Each edge kind has its own enable bank and its own sticky status bank. A single level interrupt is raised while the global gate is open and any status bit is pending.

The host uses a flat register port with a 3-bit address, a write strobe and a combinational read. Through it the host reads the line levels, sets the control bits, picks per-line rising and falling enables, clears pending requests by writing ones, and loads the debounce preload. The preload is common to every line. A free-running prescaler (`TICK_DIV` clock cycles, about 6.8 µs at the intended clock) paces the debounce counters, so one preload step is one tick.

Each debounce channel is a two-state machine. It sits in `DB_STABLE` while the synchronized level equals the filtered level. It takes transition `T_START` into `DB_PENDING` when they differ, and loads its counter from the preload at that point. From `DB_PENDING` it takes `T_BOUNCE` back to `DB_STABLE` if the level returns before time is up. It takes `T_COMMIT` to `DB_STABLE` when a tick arrives with the counter at zero; this copies the new level to the filtered output. Otherwise each tick decrements the counter. `T_LOAD` forces `DB_STABLE` and copies the synchronized level whenever debouncing is off or the block is still settling after reset.

Top module: `din_edge_irq`

## Requirements
- R1: Reading address 0 returns the line levels, line i at bit i. The value is the synchronized level, or the filtered level when debouncing is on. A change at the pins is visible within 3 clock cycles when debouncing is off.
- R2: The rising status bank (address 4) sets bit i on a 0-to-1 transition of line i only if bit i of the rising enable bank (address 2) is 1.
- R3: The falling status bank (address 5) sets bit i on a 1-to-0 transition of line i only if bit i of the falling enable bank (address 3) is 1.
- R4: A line with both its enable bits at 1 records both of its edges, each in its own bank.
- R5: Writing a status bank clears the bits written as 1 and leaves the bits written as 0 unchanged. A status bit stays set until it is cleared. If a clear and a new edge hit the same bit in the same cycle, the bit ends up set.
- R6: The control register is at address 1, with bit 0 = global interrupt enable and bit 2 = debounce enable (bit 1 reads 0). `irq` is high exactly when the global enable is 1 and at least one bit of either status bank is set.
- R7: With debouncing on and preload P (address 6), a level change is accepted only after the synchronized level has stayed at the new value for at least P ticks of `TICK_DIV` cycles. It is accepted within P+1 ticks. A shorter pulse produces no edge and no change in the level read back.
- R8: Reset clears control, enables, status and preload to 0. Levels present on the pins across reset are read back after reset and produce no status bit.
- R9: With debouncing off, a pulse of a few cycles on a line is recorded as a rising and a falling edge, with no filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | N | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | N | Register write data |
| rdata | output | N | Register read data (combinational from addr) |
| irq | output | 1 | Level interrupt request |

## Verification
The edge path is driven with a table of line patterns. Some patterns flip single lines, some flip alternating halves and some flip every line at once. Together they separate a rising edge from a falling edge on the same bit and show that no neighbouring bit is disturbed. Partial enable masks show that gating is per bit and per bank. A clear that lands in the same cycle as a new edge separates set-wins from clear-wins. With debouncing on, a pulse shorter than the programmed time is set against a level held longer, and a zero preload is tried as the shortest case. Pins held across reset show that settling creates no false edges.

// File: rtl/din_pkg.sv
package din_pkg;
    localparam logic [2:0] A_LEVEL   = 3'd0;
    localparam logic [2:0] A_CTRL    = 3'd1;
    localparam logic [2:0] A_RISE_EN = 3'd2;
    localparam logic [2:0] A_FALL_EN = 3'd3;
    localparam logic [2:0] A_RISE_ST = 3'd4;
    localparam logic [2:0] A_FALL_ST = 3'd5;
    localparam logic [2:0] A_PRELOAD = 3'd6;

    localparam int CTRL_GIE  = 0;
    localparam int CTRL_DBEN = 2;

    typedef enum logic {
        DB_STABLE,
        DB_PENDING
    } db_state_e;
endpackage

// File: rtl/din_sync.sv
module din_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1  <= '0;
            q_o <= '0;
        end else begin
            s1  <= d_i;
            q_o <= s1;
        end
    end
endmodule

// File: rtl/din_tick.sv
module din_tick #(
    parameter int DIV = 850
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + 1'b1;
    end

    assign tick_o = (cnt == LAST);
endmodule

// File: rtl/din_debounce.sv
module din_debounce
    import din_pkg::*;
#(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          tick_i,
    input  logic          level_i,
    input  logic [PW-1:0] preload_i,
    output logic          level_o
);
    db_state_e     state, state_nx;
    logic [PW-1:0] cnt;
    logic          expire;

    assign expire = tick_i && (cnt == '0);

    always_comb begin
        state_nx = state;
        unique case (state)
            DB_STABLE:  if (!load_i && level_i != level_o) state_nx = DB_PENDING;  // T_START
            DB_PENDING: if (load_i)                        state_nx = DB_STABLE;   // T_LOAD
                        else if (level_i == level_o)       state_nx = DB_STABLE;   // T_BOUNCE
                        else if (expire)                   state_nx = DB_STABLE;   // T_COMMIT
            default:                                       state_nx = DB_STABLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DB_STABLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            level_o <= 1'b0;
        end else if (load_i) begin
            level_o <= level_i;
        end else begin
            unique case (state)
                DB_STABLE:  if (level_i != level_o) cnt <= preload_i;
                DB_PENDING: if (level_i != level_o && tick_i) begin
                                if (cnt == '0) level_o <= level_i;
                                else           cnt     <= cnt - 1'b1;
                            end
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/din_edge_irq.sv
module din_edge_irq
    import din_pkg::*;
#(
    parameter int N        = 16,
    parameter int TICK_DIV = 850
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_i,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] rdata,
    output logic         irq
);
    logic [N-1:0] syn, flt, lvl, prev, rise, fall;
    logic [N-1:0] rise_en, fall_en, rise_st, fall_st, preload;
    logic [N-1:0] rclr, fclr;
    logic [1:0]   arm_cnt;
    logic         armed, gie, dben, tick, load;

    din_sync #(.W(N)) u_sync (.clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(syn));
    din_tick #(.DIV(TICK_DIV)) u_tick (.clk(clk), .rst_n(rst_n), .tick_o(tick));

    assign armed = (arm_cnt == 2'd3);
    assign load  = !armed || !dben;

    for (genvar i = 0; i < N; i++) begin : g_ch
        din_debounce #(.PW(N)) u_db (
            .clk(clk), .rst_n(rst_n), .load_i(load), .tick_i(tick),
            .level_i(syn[i]), .preload_i(preload), .level_o(flt[i])
        );
    end

    assign lvl  = dben ? flt : syn;
    assign rise = lvl & ~prev & {N{armed}};
    assign fall = ~lvl & prev & {N{armed}};
    assign rclr = (wr_en && addr == A_RISE_ST) ? wdata : '0;
    assign fclr = (wr_en && addr == A_FALL_ST) ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_cnt <= '0;
            prev    <= '0;
            gie     <= 1'b0;
            dben    <= 1'b0;
            rise_en <= '0;
            fall_en <= '0;
            rise_st <= '0;
            fall_st <= '0;
            preload <= '0;
        end else begin
            if (!armed) arm_cnt <= arm_cnt + 1'b1;
            prev    <= lvl;
            rise_st <= (rise_st & ~rclr) | (rise & rise_en);
            fall_st <= (fall_st & ~fclr) | (fall & fall_en);
            if (wr_en) begin
                unique case (addr)
                    A_CTRL: begin
                        gie  <= wdata[CTRL_GIE];
                        dben <= wdata[CTRL_DBEN];
                    end
                    A_RISE_EN: rise_en <= wdata;
                    A_FALL_EN: fall_en <= wdata;
                    A_PRELOAD: preload <= wdata;
                    default:   ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_LEVEL:   rdata = lvl;
            A_CTRL:    rdata = N'({dben, 1'b0, gie});
            A_RISE_EN: rdata = rise_en;
            A_FALL_EN: rdata = fall_en;
            A_RISE_ST: rdata = rise_st;
            A_FALL_ST: rdata = fall_st;
            A_PRELOAD: rdata = preload;
            default:   rdata = '0;
        endcase
    end

    assign irq = gie && ((|rise_st) || (|fall_st));
endmodule

// File: rtl/din_edge_irq_chk.sv
module din_edge_irq_chk
    import din_pkg::*;
#(
    parameter int N = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic [N-1:0] wdata,
    input logic [N-1:0] rise_st,
    input logic [N-1:0] fall_st,
    input logic [N-1:0] rise_en,
    input logic         dben,
    input logic         armed,
    input logic [N-1:0] flt,
    input logic         tick
);
    logic [N-1:0] rclr_m, fclr_m;
    assign rclr_m = (wr_en && addr == A_RISE_ST) ? wdata : '0;
    assign fclr_m = (wr_en && addr == A_FALL_ST) ? wdata : '0;

    // R2
    rise_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_st & ~$past(rise_st) & ~$past(rise_en)) == '0));

    // R5
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(rise_st) & ~rise_st & ~$past(rclr_m)) == '0) &&
        (($past(fall_st) & ~fall_st & ~$past(fclr_m)) == '0));

    // R4
    one_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((rise_st & ~$past(rise_st)) & (fall_st & ~$past(fall_st))) == '0));

    // R7
    filter_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dben) && $past(armed)) |-> ((flt == $past(flt)) || $past(tick)));

    // R8
    settle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> (rise_st == '0 && fall_st == '0));
endmodule

bind din_edge_irq din_edge_irq_chk #(.N(N)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rise_st(rise_st), .fall_st(fall_st), .rise_en(rise_en), .dben(dben),
    .armed(armed), .flt(flt), .tick(tick)
);

// File: tb/test_din_edge_irq.sv
module test_din_edge_irq;
    import din_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pin = 16'hA5A5;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 0;

    din_edge_irq #(.N(16), .TICK_DIV(8)) i_din_edge_irq (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    localparam int NPAT = 6;
    localparam logic [15:0] PAT [NPAT] = '{16'h0001, 16'h8001, 16'h00FF,
                                           16'hFF00, 16'hFFFF, 16'h0000};

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        wr(A_RISE_ST, 16'hFFFF);
        wr(A_FALL_ST, 16'hFFFF);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, old;
        cyc(5);
        rst_n = 1'b1;
        cyc(6);
        // R8: reset state and no false edges from held pins
        rd(A_LEVEL, v);   check("R8 level after reset", v, 16'hA5A5);
        rd(A_RISE_ST, v); check("R8 rise status", v, 16'h0);
        rd(A_FALL_ST, v); check("R8 fall status", v, 16'h0);
        rd(A_CTRL, v);    check("R8 ctrl", v, 16'h0);
        rd(A_PRELOAD, v); check("R8 preload", v, 16'h0);
        rd(A_RISE_EN, v); check("R8 rise enable", v, 16'h0);
        check("R8 irq", {15'b0, irq}, 16'h0);

        // R2 R3: disabled banks record nothing
        @(negedge clk); pin = 16'h5A5A; cyc(6);
        rd(A_RISE_ST, v); check("R2 disabled rise", v, 16'h0);
        rd(A_FALL_ST, v); check("R3 disabled fall", v, 16'h0);

        // R1 R2 R3: table walk with all enables on
        wr(A_RISE_EN, 16'hFFFF);
        wr(A_FALL_EN, 16'hFFFF);
        @(negedge clk); pin = 16'h0000; cyc(6);
        clear_all();
        old = 16'h0000;
        for (int k = 0; k < NPAT; k++) begin
            @(negedge clk); pin = PAT[k];
            cyc(5);
            rd(A_LEVEL, v);   check("R1 level", v, PAT[k]);
            rd(A_RISE_ST, v); check("R2 rise pattern", v, PAT[k] & ~old);
            rd(A_FALL_ST, v); check("R3 fall pattern", v, ~PAT[k] & old);
            clear_all();
            rd(A_RISE_ST, v); check("R5 cleared rise", v, 16'h0);
            old = PAT[k];
        end

        // R4: both edges on one line
        @(negedge clk); pin = 16'h0008; cyc(5);
        @(negedge clk); pin = 16'h0000; cyc(5);
        rd(A_RISE_ST, v); check("R4 both rise", v, 16'h0008);
        rd(A_FALL_ST, v); check("R4 both fall", v, 16'h0008);
        clear_all();

        // R2 R3: partial masks
        wr(A_RISE_EN, 16'h00FF);
        wr(A_FALL_EN, 16'h0F0F);
        @(negedge clk); pin = 16'hFFFF; cyc(5);
        rd(A_RISE_ST, v); check("R2 masked rise", v, 16'h00FF);
        @(negedge clk); pin = 16'h0000; cyc(5);
        rd(A_FALL_ST, v); check("R3 masked fall", v, 16'h0F0F);

        // R6: interrupt gate
        check("R6 irq gated off", {15'b0, irq}, 16'h0);
        wr(A_CTRL, 16'h0001);
        cyc(1);
        check("R6 irq on", {15'b0, irq}, 16'h1);

        // R5: write 0 no effect, partial clear
        wr(A_RISE_ST, 16'h0000);
        rd(A_RISE_ST, v); check("R5 write zero", v, 16'h00FF);
        wr(A_RISE_ST, 16'h000F);
        rd(A_RISE_ST, v); check("R5 partial clear", v, 16'h00F0);
        clear_all();
        cyc(1);
        check("R6 irq off after clear", {15'b0, irq}, 16'h0);

        // R5: set wins over same-cycle clear on bit 0
        wr(A_RISE_EN, 16'h0001);
        wr(A_FALL_EN, 16'h0000);
        @(negedge clk); pin = 16'h0001; cyc(5);
        @(negedge clk); pin = 16'h0000; cyc(5);
        @(negedge clk); pin = 16'h0001;
        @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; addr = A_RISE_ST; wdata = 16'h0001;
        @(posedge clk); #1 wr_en = 1'b0;
        rd(A_RISE_ST, v); check("R5 set wins", v, 16'h0001);
        wr(A_RISE_ST, 16'h0001);
        rd(A_RISE_ST, v); check("R5 clear alone", v, 16'h0);

        // R9: short pulse passes when debounce is off
        wr(A_RISE_EN, 16'hFFFF);
        wr(A_FALL_EN, 16'hFFFF);
        @(negedge clk); pin = 16'h0000; cyc(5);
        clear_all();
        @(negedge clk); pin = 16'h0010;
        @(negedge clk); @(negedge clk); @(negedge clk); pin = 16'h0000;
        cyc(5);
        rd(A_RISE_ST, v); check("R9 unfiltered rise", v, 16'h0010);
        rd(A_FALL_ST, v); check("R9 unfiltered fall", v, 16'h0010);
        clear_all();

        // R7: debounce with preload 4 (ticks of 8 cycles)
        wr(A_PRELOAD, 16'h0004);
        wr(A_CTRL, 16'h0005);
        rd(A_CTRL, v); check("R6 ctrl readback", v, 16'h0005);
        cyc(4);
        @(negedge clk); pin = 16'hFFFF; cyc(20);
        @(negedge clk); pin = 16'h0000; cyc(60);
        rd(A_RISE_ST, v); check("R7 short pulse rejected", v, 16'h0);
        rd(A_LEVEL, v);   check("R7 level unchanged", v, 16'h0);
        @(negedge clk); pin = 16'hFFFF; cyc(20);
        rd(A_RISE_ST, v); check("R7 not before time", v, 16'h0);
        rd(A_LEVEL, v);   check("R7 level held", v, 16'h0);
        cyc(40);
        rd(A_RISE_ST, v); check("R7 accepted", v, 16'hFFFF);
        rd(A_LEVEL, v);   check("R7 level new", v, 16'hFFFF);
        clear_all();
        wr(A_PRELOAD, 16'h0000);
        @(negedge clk); pin = 16'h0000; cyc(20);
        rd(A_FALL_ST, v); check("R7 zero preload", v, 16'hFFFF);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule